// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a wide binary counter assembled from identical narrow stages. Each stage holds a few bits of the count. It also has a two-bit mode select, a parallel preset input, an active-low carry input and an active-low carry output. All stages share one system clock. The only connection from one stage to the next is the carry: one stage's carry output drives the next stage's carry input directly, with no gating between them. The chain is therefore fully synchronous.

In the two counting modes, a stage's carry input acts as its clock qualifier. A stage moves by one on a clock edge only while its carry input is low. The least significant stage has its carry input tied low, so it steps on every clock. A higher stage steps only when every stage below it sits at its terminal value. In the preset and hold modes, the carry input has no effect. With the default parameters, three 4-bit stages form a 12-bit counter.

A synchronous reset clears the whole count. The final carry output shows that the whole counter is at its terminal value for the current direction. A second counter of the same kind can use it as a wrap indication or as the carry for further cascading.

Top module: `cnt_cascade`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0 after that edge, whatever the mode.
- R2: Mode 2'b00 (preset) loads `din` into the count at the next rising edge, regardless of any carry state.
- R3: Mode 2'b01 (up) raises the count by exactly one at every rising edge.
- R4: Mode 2'b10 (down) lowers the count by exactly one at every rising edge.
- R5: Mode 2'b11 (hold) leaves the count unchanged at the rising edge.
- R6: The count wraps modulo 2^12. Up from 12'hFFF gives 12'h000, and down from 12'h000 gives 12'hFFF.
- R7: `cout_n` is low exactly when the mode is up and the count is 12'hFFF, or the mode is down and the count is 12'h000. Otherwise it is high. It follows mode and count combinationally within the same cycle, and `rst` does not affect it.
- R8: In a counting mode, the bits above the lowest 4-bit stage change at an edge only if the lowest stage was at its terminal value (4'hF going up, 4'h0 going down). The same rule applies to each stage relative to all stages below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common system clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the count |
| mode | input | 2 | 00 preset, 01 up, 10 down, 11 hold |
| din | input | 12 | Parallel preset value |
| q | output | 12 | Current count |
| cout_n | output | 1 | Active-low carry/borrow out of the top stage |

## Verification
The bench builds the counter with its default parameters: three stages of four bits. This gives two internal carry links, both of which can be exercised. The 12-bit range is small enough that presets just below 12'hFFF or just above 12'h000 quickly bring each stage boundary and the full wrap into reach. Directed presets near 12'h0FF, 12'h100, 12'hFFF and 12'h000 make the carry and the borrow cross both links. Random mode and data streams, with occasional resets, cover the other transitions.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // Mode select as seen at the block boundary; the codes are fixed.
    typedef enum logic [1:0] {
        MODE_LOAD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_HOLD = 2'b11
    } cnt_mode_e;

    // Per-stage operation selected for the coming clock edge.
    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_CLEAR   = 3'd1,
        OP_PRESET  = 3'd2,
        OP_STEP_UP = 3'd3,
        OP_STEP_DN = 3'd4
    } stage_op_e;

endpackage

// File: rtl/cnt_stage_ctl.sv
// Chooses the operation of one stage for the next edge: reset wins,
// preset and hold ignore the carry input, and the count modes step only
// while the active-low carry input is asserted.
module cnt_stage_ctl
    import cnt_pkg::*;
(
    input  logic      rst,
    input  cnt_mode_e mode,
    input  logic      cin_n,
    output stage_op_e op
);

    always_comb begin
        op = OP_IDLE;
        if (rst) begin
            op = OP_CLEAR;
        end else begin
            unique case (mode)
                MODE_LOAD: op = OP_PRESET;
                MODE_UP:   op = cin_n ? OP_IDLE : OP_STEP_UP;
                MODE_DOWN: op = cin_n ? OP_IDLE : OP_STEP_DN;
                MODE_HOLD: op = OP_IDLE;
                default:   op = OP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cnt_stage_term.sv
// Terminal-value detect and active-low carry output of one stage.
module cnt_stage_term
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  cnt_mode_e      mode,
    input  logic [W-1:0]   q,
    input  logic           cin_n,
    output logic           cout_n
);

    localparam logic [W-1:0] ALL_ONES  = {W{1'b1}};
    localparam logic [W-1:0] ALL_ZEROS = {W{1'b0}};

    logic at_term;

    always_comb begin
        at_term = 1'b0;
        unique case (mode)
            MODE_UP:   at_term = (q == ALL_ONES);
            MODE_DOWN: at_term = (q == ALL_ZEROS);
            MODE_LOAD: at_term = 1'b0;
            MODE_HOLD: at_term = 1'b0;
            default:   at_term = 1'b0;
        endcase
    end

    assign cout_n = ~(at_term & ~cin_n);

endmodule

// File: rtl/cnt_stage.sv
// One counter stage: operation decode, value register, carry output.
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] d,
    input  logic         cin_n,
    output logic [W-1:0] q,
    output logic         cout_n
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    stage_op_e    op;
    logic [W-1:0] q_next;

    cnt_stage_ctl u_ctl (
        .rst   (rst),
        .mode  (mode),
        .cin_n (cin_n),
        .op    (op)
    );

    // Next-value selection.
    always_comb begin
        q_next = q;
        unique case (op)
            OP_CLEAR:   q_next = '0;
            OP_PRESET:  q_next = d;
            OP_STEP_UP: q_next = q + ONE;
            OP_STEP_DN: q_next = q - ONE;
            OP_IDLE:    q_next = q;
            default:    q_next = q;
        endcase
    end

    // Value register.
    always_ff @(posedge clk) begin
        q <= q_next;
    end

    // Carry output.
    cnt_stage_term #(.W(W)) u_term (
        .mode   (mode),
        .q      (q),
        .cin_n  (cin_n),
        .cout_n (cout_n)
    );

endmodule

// File: rtl/cnt_cascade.sv
// Chain of identical stages on one clock, linked only by the carry.
module cnt_cascade
    import cnt_pkg::*;
#(
    parameter  int STAGE_W  = 4,
    parameter  int N_STAGES = 3,
    localparam int TOTAL_W  = STAGE_W * N_STAGES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode,
    input  logic [TOTAL_W-1:0] din,
    output logic [TOTAL_W-1:0] q,
    output logic               cout_n
);

    cnt_mode_e          mode_e;
    logic [N_STAGES:0]  carry_n;

    assign mode_e     = cnt_mode_e'(mode);
    assign carry_n[0] = 1'b0;  // lowest stage always enabled

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        cnt_stage #(.W(STAGE_W)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .mode   (mode_e),
            .d      (din[s*STAGE_W +: STAGE_W]),
            .cin_n  (carry_n[s]),
            .q      (q[s*STAGE_W +: STAGE_W]),
            .cout_n (carry_n[s+1])
        );
    end

    assign cout_n = carry_n[N_STAGES];

endmodule

// File: rtl/cnt_cascade_chk.sv
module cnt_cascade_chk #(
    parameter int STAGE_W = 4,
    parameter int TOTAL_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         mode,
    input logic [TOTAL_W-1:0] din,
    input logic [TOTAL_W-1:0] q,
    input logic               cout_n
);

    localparam logic [TOTAL_W-1:0] ONE  = {{(TOTAL_W-1){1'b0}}, 1'b1};
    localparam logic [STAGE_W-1:0] LOW1 = {STAGE_W{1'b1}};

    logic started = 1'b0;
    always_ff @(posedge clk) started <= 1'b1;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!started)
        rst |=> (q == '0)); // R1

    AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> (q == $past(din))); // R2

    AST_UP_STEPS: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |=> (q == $past(q) + ONE)); // R3

    AST_DOWN_STEPS: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> (q == $past(q) - ONE)); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> $stable(q)); // R5

    AST_UP_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && q == '1) |=> (q == '0)); // R6

    AST_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
        (cout_n == !((mode == 2'b01 && q == '1) || (mode == 2'b10 && q == '0)))); // R7

    AST_UPPER_WAITS: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && q[STAGE_W-1:0] != LOW1)
        |=> (q[TOTAL_W-1:STAGE_W] == $past(q[TOTAL_W-1:STAGE_W]))); // R8

endmodule

bind cnt_cascade cnt_cascade_chk #(.STAGE_W(STAGE_W), .TOTAL_W(TOTAL_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .din    (din),
    .q      (q),
    .cout_n (cout_n)
);

// File: tb/sim_cnt_cascade.sv
`timescale 1ns/1ps
module sim_cnt_cascade;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'b11;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic         cout_n;

    int checks = 0;
    int errors = 0;
    int ref_q  = 0;

    always #2.5 clk = ~clk;

    cnt_cascade u0 (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .din    (din),
        .q      (q),
        .cout_n (cout_n)
    );

    function automatic int next_ref(int cur, logic r, logic [1:0] m, logic [W-1:0] d);
        if (r) return 0;
        case (m)
            2'b00:   return int'(d);
            2'b01:   return (cur + 1) % 4096;
            2'b10:   return (cur + 4095) % 4096;
            default: return cur;
        endcase
    endfunction

    function automatic logic exp_cout_n(int cur, logic [1:0] m);
        return !((m == 2'b01 && cur == 4095) || (m == 2'b10 && cur == 0));
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Apply inputs at the falling edge, check carry, then the count after the edge.
    task automatic step(logic r, logic [1:0] m, logic [W-1:0] d, string req);
        @(negedge clk);
        rst = r; mode = m; din = d;
        #1;
        check("R7", int'(cout_n), int'(exp_cout_n(ref_q, m)));
        @(posedge clk);
        ref_q = next_ref(ref_q, r, m, d);
        #1;
        check(req, int'(q), ref_q);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        // R1 reset state
        step(1'b1, 2'b01, 12'h5A5, "R1");
        step(1'b1, 2'b00, 12'h123, "R1");
        // R2 preset, R3 up, R6 wrap, R7 terminal carry
        step(1'b0, 2'b00, 12'hFFE, "R2");
        step(1'b0, 2'b01, 12'h000, "R3");
        step(1'b0, 2'b01, 12'h000, "R6");
        step(1'b0, 2'b10, 12'h000, "R6");
        step(1'b0, 2'b10, 12'h000, "R4");
        // R8 carry across the first and second links
        step(1'b0, 2'b00, 12'h0FE, "R2");
        step(1'b0, 2'b01, 12'h000, "R8");
        step(1'b0, 2'b01, 12'h000, "R8");
        step(1'b0, 2'b10, 12'h000, "R8");
        step(1'b0, 2'b00, 12'h001, "R2");
        step(1'b0, 2'b10, 12'h000, "R4");
        step(1'b0, 2'b10, 12'h000, "R6");
        // R5 hold, including at the terminal value
        step(1'b0, 2'b11, 12'h777, "R5");
        step(1'b0, 2'b11, 12'h000, "R5");
        // R1 reset overrides preset mid-count
        step(1'b0, 2'b00, 12'h800, "R2");
        step(1'b1, 2'b00, 12'hABC, "R1");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [1:0]   m;
            logic [W-1:0] d;
            logic         r;
            m = 2'($urandom_range(3, 0));
            d = W'($urandom);
            if ($urandom_range(7, 0) == 0) d = ($urandom_range(1, 0) == 0) ? 12'hFFE : 12'h001;
            r = ($urandom_range(63, 0) == 0);
            case (m)
                2'b00:   step(r, m, d, r ? "R1" : "R2");
                2'b01:   step(r, m, d, r ? "R1" : "R3");
                2'b10:   step(r, m, d, r ? "R1" : "R4");
                default: step(r, m, d, r ? "R1" : "R5");
            endcase
        end
        finish_run();
    end

endmodule